// File: doc/BRIEF.md
# Light-Load Loop Mode Arbiter

This block is a synchronous supervisor for a four-switch buck-boost controller. It decides whether the output is regulated by the light-load hysteretic loop or by the fixed-ripple PWM loop. The inductor ripple from peak to valley is held constant in both loops. Because of that, the choice of loop can rest on event counts alone, with no load-current threshold. The arbiter watches three inputs: the output of the hysteresis comparator, the zero-current flag of the inductor and a strobe that marks each switching-cycle boundary.

In hysteretic mode the current swings between the peak limit and zero. The arbiter asks the stage to skip pulses whenever the comparator says the output is high. The arbiter hands control to the PWM loop once the valley current has stayed above zero for a full run of clock cycles. In PWM mode it counts consecutive burst cycles, meaning switching cycles in which the comparator rose and pulses were skipped. After a full run of them it hands control back to the hysteretic loop. Every hand-over emits a one-clock request, so that both references move together.

All pins are plain level or pulse control signals. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `loop_arbiter`

## Requirements
- R1: While reset is asserted and right after it is released, `pwm_sel` is 0 (hysteretic loop), `skip_en` is 0 and `ref_adj` is 0.
- R2: `skip_en` equals the value `hys_cmp` had on the previous clock edge, in either loop.
- R3: In hysteretic mode, `pwm_sel` becomes 1 on the first clock edge where `cyc_strobe` is 1 and `zc_flag` is 0, provided that `zc_flag` was 0 on at least UP_COUNT (default 32) preceding consecutive edges.
- R4: In hysteretic mode, any edge with `zc_flag` high restarts the run of zero-free clocks from zero.
- R5: In PWM mode, `pwm_sel` returns to 0 at the strobe edge that closes the BURST_COUNT-th (default 8) consecutive burst cycle. A switching cycle spans the edges after one strobe edge up to and including the next strobe edge. It is a burst cycle if `hys_cmp` was 1 on any of those edges.
- R6: In PWM mode, a switching cycle with `hys_cmp` 0 on all of its edges restarts the burst run from zero.
- R7: `pwm_sel` changes only on a clock edge where `cyc_strobe` is 1.
- R8: `ref_adj` is high for exactly the one clock that follows each change of `pwm_sel`, and is low at every other time.
- R9: Each loop change starts the count of the new mode from zero. `zc_flag` has no effect on `pwm_sel` while in PWM mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hys_cmp | input | 1 | Hysteresis comparator output, 1 when the feedback is above the upper threshold |
| zc_flag | input | 1 | Inductor current has reached zero |
| cyc_strobe | input | 1 | One-clock pulse that closes a switching cycle |
| pwm_sel | output | 1 | Loop select: 0 hysteretic, 1 PWM |
| skip_en | output | 1 | Pulse-skip (sleep) request |
| ref_adj | output | 1 | One-clock reference-adjust request on each loop change |

## Verification
The bench probes the off-by-one edges of both runs. It gives exactly UP_COUNT-1 zero-free clocks before a strobe and checks that no hand-over happens; an arbiter that counted one clock short would switch early. It gives BURST_COUNT-1 burst cycles, then a quiet cycle, then a fresh run. An arbiter that forgot to clear its counter would return to hysteretic mode too soon. The bench also raises `zc_flag` during PWM and holds a qualified count while no strobe arrives, which exposes a design that switches in the middle of a cycle or reacts to zero-current in the wrong loop.

// File: rtl/loop_arb_pkg.sv
package loop_arb_pkg;
  typedef enum logic {
    LOOP_HYS = 1'b0,
    LOOP_PWM = 1'b1
  } loop_e;
endpackage

// File: rtl/loop_arb_valley_run.sv
// Counts consecutive clocks without a zero-current flag while enabled.
module loop_arb_valley_run #(
  parameter int UP_COUNT = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic zc_flag,
  output logic run_done
);
  localparam int CW = $clog2(UP_COUNT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(UP_COUNT);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (!en || zc_flag) begin
      run_q <= '0;
    end else if (run_q != LIMIT) begin
      run_q <= run_q + 1'b1;
    end
  end

  assign run_done = (run_q == LIMIT);

  // R4: a zero-current event restarts the run
  p_zc_restarts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && zc_flag) |=> (run_q == '0));
  // R3: the run saturates and never overshoots its limit
  p_run_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= LIMIT);
endmodule

// File: rtl/loop_arb_burst_run.sv
// Counts consecutive switching cycles that contain a comparator-high event.
module loop_arb_burst_run #(
  parameter int BURST_COUNT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic hys_cmp,
  input  logic cyc_strobe,
  output logic burst_hit
);
  localparam int CW = $clog2(BURST_COUNT + 1);
  localparam logic [CW-1:0] LAST = CW'(BURST_COUNT - 1);

  logic [CW-1:0] run_q;
  logic          seen_q;
  logic          cyc_burst;

  assign cyc_burst = seen_q | hys_cmp;
  assign burst_hit = en && cyc_strobe && cyc_burst && (run_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      seen_q <= 1'b0;
    end else if (!en) begin
      run_q  <= '0;
      seen_q <= 1'b0;
    end else if (cyc_strobe) begin
      seen_q <= 1'b0;
      if (!cyc_burst || burst_hit) run_q <= '0;
      else                         run_q <= run_q + 1'b1;
    end else begin
      seen_q <= cyc_burst;
    end
  end

  // R6: a quiet switching cycle restarts the burst run
  p_quiet_restarts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cyc_strobe && !hys_cmp && !seen_q) |=> (run_q == '0));
  // R5: the run never exceeds the last count before a hand-over
  p_burst_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= LAST);
endmodule

// File: rtl/loop_arbiter.sv
module loop_arbiter #(
  parameter int UP_COUNT    = 32,
  parameter int BURST_COUNT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hys_cmp,
  input  logic zc_flag,
  input  logic cyc_strobe,
  output logic pwm_sel,
  output logic skip_en,
  output logic ref_adj
);
  import loop_arb_pkg::*;

  loop_e mode_q;
  logic  run_done;
  logic  burst_hit;
  logic  go_pwm;
  logic  go_hys;
  logic  skip_q;
  logic  ref_q;

  loop_arb_valley_run #(.UP_COUNT(UP_COUNT)) u_valley (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (mode_q == LOOP_HYS),
    .zc_flag  (zc_flag),
    .run_done (run_done)
  );

  loop_arb_burst_run #(.BURST_COUNT(BURST_COUNT)) u_burst (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (mode_q == LOOP_PWM),
    .hys_cmp    (hys_cmp),
    .cyc_strobe (cyc_strobe),
    .burst_hit  (burst_hit)
  );

  assign go_pwm = (mode_q == LOOP_HYS) && cyc_strobe && !zc_flag && run_done;
  assign go_hys = (mode_q == LOOP_PWM) && burst_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= LOOP_HYS;
      skip_q <= 1'b0;
      ref_q  <= 1'b0;
    end else begin
      skip_q <= hys_cmp;
      ref_q  <= go_pwm | go_hys;
      if (go_pwm)      mode_q <= LOOP_PWM;
      else if (go_hys) mode_q <= LOOP_HYS;
    end
  end

  assign pwm_sel = (mode_q == LOOP_PWM);
  assign skip_en = skip_q;
  assign ref_adj = ref_q;

  // R7: loop select moves only at a switching-cycle boundary
  p_change_on_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_sel != $past(pwm_sel)) |-> $past(cyc_strobe));
  // R8: reference request pulses exactly when the loop changed
  p_ref_with_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ref_adj == (pwm_sel != $past(pwm_sel)));
  // R2: skip request follows the comparator by one clock
  p_skip_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (skip_en == $past(hys_cmp)));
  // R3: entry to PWM only from a completed zero-free run
  p_pwm_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_sel) |-> $past(run_done && !zc_flag));
endmodule

// File: tb/loop_arbiter_tb.sv
module loop_arbiter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int UP  = 32;
  localparam int BST = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hys = 1'b0, zc = 1'b0, st = 1'b0;
  logic pwm_sel, skip_en, ref_adj;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  loop_arbiter #(.UP_COUNT(UP), .BURST_COUNT(BST)) u_dut (
    .clk(clk), .rst_n(rst_n), .hys_cmp(hys), .zc_flag(zc), .cyc_strobe(st),
    .pwm_sel(pwm_sel), .skip_en(skip_en), .ref_adj(ref_adj)
  );

  // Reference model built from the requirements
  logic m_mode, m_skip, m_ref, m_seen;
  int   m_up, m_dn;

  function automatic int next_run(int run, logic z);
    if (z) return 0;
    return (run >= UP) ? UP : run + 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode <= 1'b0; m_skip <= 1'b0; m_ref <= 1'b0; m_seen <= 1'b0;
      m_up <= 0; m_dn <= 0;
    end else begin
      m_skip <= hys;
      m_ref  <= 1'b0;
      if (!m_mode) begin
        m_seen <= 1'b0; m_dn <= 0;
        if (st && !zc && m_up == UP) begin
          m_mode <= 1'b1; m_ref <= 1'b1; m_up <= 0;
        end else begin
          m_up <= next_run(m_up, zc);
        end
      end else begin
        m_up <= 0;
        if (st) begin
          m_seen <= 1'b0;
          if (m_seen || hys) begin
            if (m_dn == BST - 1) begin
              m_mode <= 1'b0; m_ref <= 1'b1; m_dn <= 0;
            end else m_dn <= m_dn + 1;
          end else m_dn <= 0;
        end else m_seen <= m_seen | hys;
      end
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(logic z, logic h, logic s);
    @(negedge clk);
    chk("R3/R5/R7 pwm_sel", pwm_sel, m_mode);
    chk("R2 skip_en", skip_en, m_skip);
    chk("R8 ref_adj", ref_adj, m_ref);
    zc = z; hys = h; st = s;
    @(posedge clk);
  endtask

  task automatic burst_cycle(logic z);
    step(z, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    int per;
    int ph;
    logic s;
    void'($urandom(32'd20517));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 pwm_sel in reset", pwm_sel, 1'b0);
    chk("R1 skip_en in reset", skip_en, 1'b0);
    chk("R1 ref_adj in reset", ref_adj, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 pwm_sel after reset", pwm_sel, 1'b0);

    // R4: a zero-current edge restarts the run
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 31; i++) step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b1); #1;
    chk("R4 no hand-over one clock short", pwm_sel, 1'b0);
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 1'b0); #1;
    chk("R7 no hand-over without strobe", pwm_sel, 1'b0);
    step(1'b0, 1'b0, 1'b1); #1;
    chk("R3 entry to PWM", pwm_sel, 1'b1);
    chk("R8 ref pulse on entry", ref_adj, 1'b1);
    step(1'b0, 1'b0, 1'b0); #1;
    chk("R8 ref pulse is one clock", ref_adj, 1'b0);

    // R6 and R9: quiet cycle restarts burst run; zc ignored in PWM
    for (int i = 0; i < BST - 1; i++) burst_cycle(1'b1);
    step(1'b1, 1'b0, 1'b0); step(1'b0, 1'b0, 1'b1); #1;
    chk("R6 quiet cycle keeps PWM", pwm_sel, 1'b1);
    for (int i = 0; i < BST - 1; i++) burst_cycle(1'b0); #1;
    chk("R6 run restarted after quiet cycle", pwm_sel, 1'b1);
    chk("R9 zc ignored in PWM", pwm_sel, 1'b1);
    burst_cycle(1'b0); #1;
    chk("R5 return to hysteretic", pwm_sel, 1'b0);
    chk("R8 ref pulse on return", ref_adj, 1'b1);

    // R9: fresh run needed after returning
    for (int i = 0; i < UP - 1; i++) step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b1); #1;
    chk("R9 run restarts after return", pwm_sel, 1'b0);

    // Random stimulus
    for (int r = 0; r < 60; r++) begin
      per = 3 + int'($urandom % 10);
      ph = 0;
      for (int k = 0; k < 400; k++) begin
        s = (ph == per - 1);
        ph = s ? 0 : ph + 1;
        if (!m_mode) step(($urandom % 50) == 0, ($urandom % 4) == 0, s);
        else         step(($urandom % 6) == 0, ($urandom % 5) != 0, s);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule